// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a configuration register file that a host reaches through two byte-wide I/O addresses: an index address that points at a register, and a data address that reads or writes the register being pointed at. The register file is protected by an unlock sequence. A host writes a two-byte key to the index address to open the port and a single exit byte to close it. While the port is closed, register contents cannot be changed and reads return all ones.

Behind the port sit a few global registers and one register bank per logical device. A device-select register picks which bank the upper index range reaches. Each bank holds the following fields, and drives all of them as outputs to its device block:
- an activate bit
- a 16-bit base address
- two interrupt numbers
- a DMA channel
- a row of device-specific mode bytes

A global soft-reset bit clears every bank in a single cycle.

Top module: `cfg_keyport`

## Requirements
- R1: The port opens (`cfg_open` = 1) after two consecutive index-port writes of 0x51 and then 0x23. If the second byte is anything other than 0x23, the port stays closed. If the second byte is 0x51, the port waits for 0x23 again.
- R2: While the port is open, an index-port write of 0xBB closes it and leaves the index register unchanged.
- R3: While the port is closed, data-port writes are ignored and index-port writes only advance the key. A read of either address returns 0xFF.
- R4: A read strobe (`bus_rd`) captures a value into `bus_rdata`, which is valid from the following clock cycle. While the port is open, an index-port read (`bus_sel_data` = 0) returns the index register. A data-port read (`bus_sel_data` = 1) returns the register that the index points at.
- R5: Global index 0x07 is the device-select register. It can be written and read back.
- R6: In the selected bank, index 0x30 bit 0 is the activate bit, driven on `dev_active[dev]`. Bits 7:1 of index 0x30 read as 0.
- R7: Bank index 0x60 holds base-address bits 15:8 and index 0x61 holds bits 7:0. Together they are driven on `dev_base[dev*16 +: 16]`.
- R8: Bank indices 0x70, 0x72 and 0x74 hold the first IRQ, the second IRQ and the DMA channel. They are driven on `dev_irq_a`, `dev_irq_b` and `dev_dma`, each in the byte slot `[dev*8 +: 8]`.
- R9: Bank indices 0xF0 to 0xF0+MODE_N-1 hold mode bytes. These are stored and driven unchanged on `dev_mode`, with mode byte k of device d at bit offset (d*MODE_N+k)*8.
- R10: A bank write reaches only the bank of the currently selected device. When the select value is NDEV or greater, bank writes change nothing and bank reads return 0x00.
- R11: Indices that are not implemented read as 0x00, and writes to them change no output.
- R12: A data write of bit 0 = 1 to global index 0x02 clears every bank and the device-select register in that cycle, and the port stays open. Index 0x02 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_data | input | 1 | Address select: 0 = index address, 1 = data address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the read strobe |
| cfg_open | output | 1 | Port is unlocked |
| dev_active | output | NDEV | Activate bit of each device |
| dev_base | output | NDEV*16 | Base address of each device |
| dev_irq_a | output | NDEV*8 | First IRQ number of each device |
| dev_irq_b | output | NDEV*8 | Second IRQ number of each device |
| dev_dma | output | NDEV*8 | DMA channel of each device |
| dev_mode | output | NDEV*MODE_N*8 | Mode bytes of each device |

## Verification
The bench builds the block with its default values, NDEV = 9 and MODE_N = 5. With nine banks, the highest device (8) can be programmed. It also means that a select value of 9 falls just past the last bank, which exercises the out-of-range path. With five mode bytes, 0xF5 is the first unimplemented index above the mode row, so the bench checks both the last stored mode byte and the first index that must read as zero.

// File: rtl/cfg_keyport_pkg.sv
`timescale 1ns/1ps
package cfg_keyport_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h51;
    localparam logic [7:0] KEY_SECOND = 8'h23;
    localparam logic [7:0] KEY_EXIT   = 8'hBB;

    localparam logic [7:0] IX_SOFTRST = 8'h02;
    localparam logic [7:0] IX_DEVSEL  = 8'h07;
    localparam logic [7:0] IX_BANK_LO = 8'h30;
    localparam logic [7:0] IX_ACT     = 8'h30;
    localparam logic [7:0] IX_BASE_HI = 8'h60;
    localparam logic [7:0] IX_BASE_LO = 8'h61;
    localparam logic [7:0] IX_IRQ_A   = 8'h70;
    localparam logic [7:0] IX_IRQ_B   = 8'h72;
    localparam logic [7:0] IX_DMA     = 8'h74;
    localparam logic [7:0] IX_MODE0   = 8'hF0;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_st_e;

    typedef struct packed {
        logic        act;
        logic [15:0] base;
        logic [7:0]  irq_a;
        logic [7:0]  irq_b;
        logic [7:0]  dma;
    } dev_cfg_t;
endpackage

// File: rtl/cfg_key_fsm.sv
`timescale 1ns/1ps
module cfg_key_fsm
    import cfg_keyport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open
);
    key_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            case (st_q)
                KS_LOCKED: if (wdata == KEY_FIRST) st_d = KS_HALF;
                KS_HALF: begin
                    if (wdata == KEY_SECOND)     st_d = KS_OPEN;
                    else if (wdata == KEY_FIRST) st_d = KS_HALF;
                    else                         st_d = KS_LOCKED;
                end
                KS_OPEN:   if (wdata == KEY_EXIT) st_d = KS_LOCKED;
                default:   st_d = KS_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_LOCKED;
        else        st_q <= st_d;
    end

    assign open = (st_q == KS_OPEN);

    // R1: a closed port stays closed unless the second key byte arrives
    a_r1_no_open_without_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !(idx_wr && wdata == KEY_SECOND)) |=> !open);

    // R2: the exit byte always relocks
    a_r2_exit_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (open && idx_wr && wdata == KEY_EXIT) |=> !open);
endmodule

// File: rtl/cfg_dev_bank.sv
`timescale 1ns/1ps
module cfg_dev_bank
    import cfg_keyport_pkg::*;
#(
    parameter int MODE_N = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [7:0]          idx,
    input  logic [7:0]          wdata,
    output dev_cfg_t            cfg,
    output logic [MODE_N*8-1:0] mode,
    output logic [7:0]          rd_data
);
    typedef struct packed {
        dev_cfg_t                cfg;
        logic [MODE_N-1:0][7:0]  mode;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (soft_rst) begin
            s_d = '0;
        end else if (wr_en) begin
            case (idx)
                IX_ACT:     s_d.cfg.act        = wdata[0];
                IX_BASE_HI: s_d.cfg.base[15:8] = wdata;
                IX_BASE_LO: s_d.cfg.base[7:0]  = wdata;
                IX_IRQ_A:   s_d.cfg.irq_a      = wdata;
                IX_IRQ_B:   s_d.cfg.irq_b      = wdata;
                IX_DMA:     s_d.cfg.dma        = wdata;
                default: ;
            endcase
            for (int k = 0; k < MODE_N; k++) begin
                if (idx == IX_MODE0 + 8'(k)) s_d.mode[k] = wdata;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        case (idx)
            IX_ACT:     rd_data = {7'b0, s_q.cfg.act};
            IX_BASE_HI: rd_data = s_q.cfg.base[15:8];
            IX_BASE_LO: rd_data = s_q.cfg.base[7:0];
            IX_IRQ_A:   rd_data = s_q.cfg.irq_a;
            IX_IRQ_B:   rd_data = s_q.cfg.irq_b;
            IX_DMA:     rd_data = s_q.cfg.dma;
            default: ;
        endcase
        for (int k = 0; k < MODE_N; k++) begin
            if (idx == IX_MODE0 + 8'(k)) rd_data = s_q.mode[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg  = s_q.cfg;
    assign mode = s_q.mode;

    // R3 / R10: a bank that is not written keeps its contents
    a_r10_idle_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !soft_rst) |=> $stable(s_q));

    // R12: soft reset empties the bank on the next edge
    a_r12_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg == '0 && mode == '0));
endmodule

// File: rtl/cfg_keyport.sv
`timescale 1ns/1ps
module cfg_keyport
    import cfg_keyport_pkg::*;
#(
    parameter int NDEV   = 9,
    parameter int MODE_N = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel_data,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    output logic                       cfg_open,
    output logic [NDEV-1:0]            dev_active,
    output logic [NDEV*16-1:0]         dev_base,
    output logic [NDEV*8-1:0]          dev_irq_a,
    output logic [NDEV*8-1:0]          dev_irq_b,
    output logic [NDEV*8-1:0]          dev_dma,
    output logic [NDEV*MODE_N*8-1:0]   dev_mode
);
    localparam int MODE_W = MODE_N * 8;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] sel;
        logic [7:0] rdata;
    } port_t;

    port_t p_d, p_q;

    logic                     idx_wr, dat_wr, soft_rst, bank_wr;
    logic [NDEV-1:0]          bank_we;
    logic [NDEV-1:0][7:0]     bank_rd;
    dev_cfg_t                 bank_cfg [NDEV];
    logic [7:0]               rd_val;

    assign idx_wr   = bus_wr && !bus_sel_data;
    assign dat_wr   = bus_wr && bus_sel_data && cfg_open;
    assign soft_rst = dat_wr && (p_q.idx == IX_SOFTRST) && bus_wdata[0];
    assign bank_wr  = dat_wr && (p_q.idx >= IX_BANK_LO);

    cfg_key_fsm u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (bus_wdata),
        .open   (cfg_open)
    );

    for (genvar i = 0; i < NDEV; i++) begin : g_bank
        assign bank_we[i] = bank_wr && (p_q.sel == 8'(i));

        cfg_dev_bank #(.MODE_N(MODE_N)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .wr_en    (bank_we[i]),
            .idx      (p_q.idx),
            .wdata    (bus_wdata),
            .cfg      (bank_cfg[i]),
            .mode     (dev_mode[i*MODE_W +: MODE_W]),
            .rd_data  (bank_rd[i])
        );

        assign dev_active[i]         = bank_cfg[i].act;
        assign dev_base[i*16 +: 16]  = bank_cfg[i].base;
        assign dev_irq_a[i*8 +: 8]   = bank_cfg[i].irq_a;
        assign dev_irq_b[i*8 +: 8]   = bank_cfg[i].irq_b;
        assign dev_dma[i*8 +: 8]     = bank_cfg[i].dma;
    end

    always_comb begin
        rd_val = 8'h00;
        if (!cfg_open) begin
            rd_val = 8'hFF;
        end else if (!bus_sel_data) begin
            rd_val = p_q.idx;
        end else if (p_q.idx == IX_DEVSEL) begin
            rd_val = p_q.sel;
        end else if (p_q.idx >= IX_BANK_LO) begin
            for (int i = 0; i < NDEV; i++) begin
                if (p_q.sel == 8'(i)) rd_val = bank_rd[i];
            end
        end
    end

    always_comb begin
        p_d = p_q;
        if (idx_wr && cfg_open && bus_wdata != KEY_EXIT) p_d.idx = bus_wdata;
        if (soft_rst)                                         p_d.sel = 8'h00;
        else if (dat_wr && p_q.idx == IX_DEVSEL)              p_d.sel = bus_wdata;
        if (bus_rd)                                           p_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_rdata = p_q.rdata;

    // R3: reads of a closed port give all ones
    a_r3_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_open) |=> (bus_rdata == 8'hFF));

    // R10: at most one bank takes a write
    a_r10_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R2: the index register survives the exit byte
    a_r2_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && bus_wdata == KEY_EXIT) |=> $stable(p_q.idx));

    // R12: soft reset returns the device select to zero
    a_r12_sel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (p_q.sel == 8'h00));
endmodule

// File: tb/sim_cfg_keyport.sv
`timescale 1ns/1ps
module sim_cfg_keyport;
    localparam int NDEV   = 9;
    localparam int MODE_N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel_data = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic cfg_open;
    logic [NDEV-1:0] dev_active;
    logic [NDEV*16-1:0] dev_base;
    logic [NDEV*8-1:0] dev_irq_a, dev_irq_b, dev_dma;
    logic [NDEV*MODE_N*8-1:0] dev_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    cfg_keyport #(.NDEV(NDEV), .MODE_N(MODE_N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel_data(bus_sel_data), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_open(cfg_open), .dev_active(dev_active), .dev_base(dev_base),
        .dev_irq_a(dev_irq_a), .dev_irq_b(dev_irq_b), .dev_dma(dev_dma),
        .dev_mode(dev_mode)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel_data = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel_data = sel; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
        wr(1'b0, ix); wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        wr(1'b0, ix); rd(1'b1, exp, tag);
    endtask

    task automatic unlock();
        wr(1'b0, 8'h51); wr(1'b0, 8'h23);
    endtask

    // monitor: pops the expected read data one cycle after each strobe
    always begin
        @(posedge clk);
        if (bus_rd) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4: unexpected read data %0h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), {56'b0, bus_rdata}, {56'b0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state and closed-port behaviour
        check("R3 reset closed", {63'b0, cfg_open}, 64'd0);
        check("R3 reset outputs", {55'b0, dev_active}, 64'd0);
        rd(1'b1, 8'hFF, "R3 locked data read");
        rd(1'b0, 8'hFF, "R3 locked index read");
        wr(1'b1, 8'h01);
        check("R3 locked write ignored", {55'b0, dev_active}, 64'd0);

        // key sequence
        wr(1'b0, 8'h51); wr(1'b0, 8'h22);
        check("R1 wrong second byte", {63'b0, cfg_open}, 64'd0);
        wr(1'b0, 8'h23);
        check("R1 lone second byte", {63'b0, cfg_open}, 64'd0);
        wr(1'b0, 8'h51); wr(1'b0, 8'h51); wr(1'b0, 8'h23);
        check("R1 restart then open", {63'b0, cfg_open}, 64'd1);
        rd(1'b0, 8'h00, "R4 index after unlock");
        rd(1'b1, 8'h00, "R3 locked write left index 0 at zero");

        // device 4
        reg_wr(8'h07, 8'h04);
        rd(1'b1, 8'h04, "R5 select readback");
        reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8);
        reg_wr(8'h70, 8'h04); reg_wr(8'h72, 8'h0C); reg_wr(8'h74, 8'h02);
        reg_wr(8'h30, 8'hFF);
        check("R7 base dev4", {48'b0, dev_base[4*16 +: 16]}, 64'h03F8);
        check("R8 irq_a dev4", {56'b0, dev_irq_a[4*8 +: 8]}, 64'h04);
        check("R8 irq_b dev4", {56'b0, dev_irq_b[4*8 +: 8]}, 64'h0C);
        check("R8 dma dev4", {56'b0, dev_dma[4*8 +: 8]}, 64'h02);
        check("R6 active dev4", {55'b0, dev_active}, 64'h010);
        reg_rd(8'h30, 8'h01, "R6 activate readback");
        reg_rd(8'h60, 8'h03, "R7 base high readback");
        reg_rd(8'h72, 8'h0C, "R8 irq_b readback");

        // device 5 must not disturb device 4
        reg_wr(8'h07, 8'h05);
        reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'hF8); reg_wr(8'h30, 8'h01);
        check("R10 dev4 untouched", {48'b0, dev_base[4*16 +: 16]}, 64'h03F8);
        check("R10 dev5 base", {48'b0, dev_base[5*16 +: 16]}, 64'h02F8);
        check("R10 active set", {55'b0, dev_active}, 64'h030);

        // device 8 mode bytes
        reg_wr(8'h07, 8'h08);
        for (int k = 0; k < MODE_N; k++) reg_wr(8'hF0 + 8'(k), 8'hA0 + 8'(k));
        for (int k = 0; k < MODE_N; k++)
            check("R9 mode byte", {56'b0, dev_mode[(8*MODE_N + k)*8 +: 8]}, {56'b0, 8'hA0 + 8'(k)});
        reg_rd(8'hF4, 8'hA4, "R9 last mode readback");
        reg_wr(8'hF5, 8'h77);
        rd(1'b1, 8'h00, "R11 index past mode row");
        reg_wr(8'h50, 8'h5A);
        rd(1'b1, 8'h00, "R11 unused bank index");
        reg_wr(8'h10, 8'h5A);
        rd(1'b1, 8'h00, "R11 unused global index");
        check("R11 no output change", {48'b0, dev_base[8*16 +: 16]}, 64'h0000);

        // out-of-range select
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h01);
        check("R10 out of range write", {55'b0, dev_active}, 64'h030);
        rd(1'b1, 8'h00, "R10 out of range read");
        rd(1'b0, 8'h30, "R4 index readback");

        // relock
        reg_wr(8'h07, 8'h04);
        wr(1'b0, 8'h30);
        wr(1'b0, 8'hBB);
        check("R2 relocked", {63'b0, cfg_open}, 64'd0);
        rd(1'b0, 8'hFF, "R3 index read after relock");
        wr(1'b1, 8'h00);
        check("R3 write after relock ignored", {55'b0, dev_active}, 64'h030);
        unlock();
        rd(1'b0, 8'h30, "R2 index kept across relock and key");

        // soft reset
        reg_wr(8'h02, 8'h00);
        check("R12 bit0 clear no reset", {55'b0, dev_active}, 64'h030);
        reg_wr(8'h02, 8'h01);
        check("R12 active cleared", {55'b0, dev_active}, 64'd0);
        check("R12 base cleared", {48'b0, dev_base[4*16 +: 16]}, 64'd0);
        check("R12 mode cleared", {56'b0, dev_mode[(8*MODE_N)*8 +: 8]}, 64'd0);
        check("R12 still open", {63'b0, cfg_open}, 64'd1);
        rd(1'b1, 8'h00, "R12 index 02 reads zero");
        reg_rd(8'h07, 8'h00, "R12 select cleared");
        reg_rd(8'h60, 8'h00, "R12 bank 0 base zero");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R4: pending reads %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule